// File: doc/BRIEF.md
# Motor Supply Overcurrent Trip Supervisor

This block sits beside a motor supply switch and reads a stream of sampled load-current and output-voltage codes. Each sample is checked against two current levels. At or above the lower level the supply is in its controlled limiting plateau. Above the higher level a timed trip window starts. If the current stays above the higher level for a programmed number of consecutive samples, the block requests that the switch open. For the whole time the current sits at or above the lower level, the block also sums the square of the current. When that sum goes past a programmed energy budget, which already includes any temperature derating, the switch is opened even though the trip window has not run out.

Every trip is latched. It raises FAULT and the switch-off request and records a cause code, and all three hold until a restart controller pulses the clear input. The cause code separates three trips. A cable short is an over-threshold run that included a sample where the voltage fell steeply while the current jumped. A hard overcurrent is an over-threshold run without that edge. A locked rotor is a trip on the energy budget while the current sat on the limiting plateau. A configuration whose two current levels are too close together is flagged, and any sample taken while it is flagged trips the block with its own code.

Samples enter through a valid/ready port. The block never applies back-pressure: ready is high whenever reset is released, and every cycle with valid high is one sample. The block holds no samples in a queue. While a trip is latched, samples are still accepted but they are discarded.

Top module: `fs_trip_supervisor`

## Requirements
- R1: `smp_ready` is high whenever `rst_n` is high. A sample is taken on each rising clock edge where `smp_valid` and `smp_ready` are both high.
- R2: A fast trip fires on the sample that completes a run of `cfg_win` consecutive taken samples with `smp_cur > cfg_ift`. A `cfg_win` of 0 acts as 1. A taken sample at or below `cfg_ift` resets the run. Cycles with `smp_valid` low neither extend the run nor reset it.
- R3: `limiting` is registered and updates on each taken sample. It goes high when `cfg_ilim <= smp_cur` and low otherwise. It is forced low while a trip is latched.
- R4: On each taken sample with `smp_cur >= cfg_ilim`, the square of `smp_cur` is added to an energy total that saturates at all ones and never wraps. The block trips on the sample whose new total is greater than `cfg_i2t_lim`.
- R5: Each taken sample below `cfg_ilim` counts toward a quiet run. When `cfg_quiet` consecutive such samples have been taken, the energy total clears (a `cfg_quiet` of 0 clears on the first one). Any sample at or above `cfg_ilim` restarts the quiet run and leaves the total in place.
- R6: `cfg_bad` is high while `5*cfg_ilim > 4*cfg_ift`, meaning the limit level is above 0.8 of the trip level. Any sample taken while `cfg_bad` is high trips with code 4.
- R7: `evt_code` values: 0 means no trip, 1 a cable short, 2 a locked rotor (energy trip), 3 a hard overcurrent, 4 a rejected configuration. A fast trip is coded 1 when some sample in its over-threshold run had the voltage fall by at least `cfg_vdrop` and the current rise by at least `cfg_dirise` compared with the previous taken sample. Otherwise it is coded 3.
- R8: On the clock edge that takes a tripping sample, `fault` and `sw_off` both go high and `evt_code` is loaded. They hold until a clear. Samples taken while a trip is latched change no output and no internal state.
- R9: A high `clr` on a clock edge drops `fault` and `sw_off`, sets `evt_code` to 0, and empties the trip run, the energy total and the quiet run. It overrides a sample taken on the same edge.
- R10: When several trips hit the same sample, the code chosen follows the order: configuration reject, then fast trip (1 or 3), then energy trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_ready | output | 1 | Sample accept, high out of reset |
| smp_cur | input | CW | Load current code |
| smp_volt | input | VW | Output voltage code |
| cfg_ift | input | CW | Fast-trip current level |
| cfg_ilim | input | CW | Limiting plateau level |
| cfg_win | input | WIN_W | Trip window in samples |
| cfg_i2t_lim | input | ACC_W | Energy budget |
| cfg_quiet | input | QW | Quiet samples before the energy total clears |
| cfg_vdrop | input | VW | Voltage fall per sample that marks a short |
| cfg_dirise | input | CW | Current rise per sample that marks a short |
| clr | input | 1 | Clear pulse from the restart controller |
| sw_off | output | 1 | Latched switch-off request |
| fault | output | 1 | Latched fault line |
| limiting | output | 1 | Current on the limiting plateau |
| evt_code | output | 3 | Latched trip cause |
| cfg_bad | output | 1 | Threshold separation violated |

## Verification
The bench places over-threshold runs one sample short of the window, and it spreads runs out with idle cycles. A design that counted clock cycles, or tripped on brief spikes, would trip early. To reach the overflow point, the energy total is driven through about 4300 samples against a budget one below full scale: a wrapping total would never trip there. Quiet runs that are exactly long enough and one sample short are checked against the trip point, and this exposes an off-by-one in the clear. The remaining tests cover priority collisions with a window of 1 and of 0, the separation limit exactly at 0.8 and just above it, and short-versus-hard coding. They show up a wrong cause code, a swapped priority, or a latch that samples taken while tripped can overwrite.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [2:0] {
    EVT_NONE   = 3'd0,
    EVT_SHORT  = 3'd1,
    EVT_LOCKED = 3'd2,
    EVT_HARD   = 3'd3,
    EVT_CFG    = 3'd4
  } fs_evt_e;
endpackage

// File: rtl/fs_cfg_check.sv
// Rejects limit levels above 0.8 of the fast-trip level: 5*ilim > 4*ift.
module fs_cfg_check #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] ift,
  input  logic [CW-1:0] ilim,
  output logic          bad
);
  localparam int XW = CW + 3;
  logic [XW-1:0] lim5;
  logic [XW-1:0] ft4;

  always_comb begin
    lim5 = {1'b0, ilim, 2'b00} + {3'b000, ilim};
    ft4  = {1'b0, ift, 2'b00};
    bad  = lim5 > ft4;
  end
endmodule

// File: rtl/fs_window.sv
// Counts consecutive over-threshold samples and remembers a steep edge.
module fs_window #(
  parameter int CW    = 12,
  parameter int VW    = 12,
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             take,
  input  logic [CW-1:0]    cur,
  input  logic [VW-1:0]    volt,
  input  logic [CW-1:0]    ift,
  input  logic [WIN_W-1:0] win,
  input  logic [VW-1:0]    vdrop,
  input  logic [CW-1:0]    dirise,
  output logic             fire,
  output logic             steep_any
);
  localparam int NW = WIN_W + 1;

  logic [WIN_W-1:0] run_q;
  logic             steep_q;
  logic [CW-1:0]    prev_cur_q;
  logic [VW-1:0]    prev_volt_q;
  logic             over;
  logic             steep_now;
  logic [NW-1:0]    run_inc;
  logic [NW-1:0]    win_eff;

  always_comb begin
    over      = cur > ift;
    run_inc   = {1'b0, run_q} + NW'(1);
    win_eff   = (win == '0) ? NW'(1) : {1'b0, win};
    steep_now = (prev_volt_q > volt) && ((prev_volt_q - volt) >= vdrop) &&
                (cur > prev_cur_q) && ((cur - prev_cur_q) >= dirise);
    steep_any = steep_q | steep_now;
    fire      = take && over && (run_inc >= win_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= '0;
      steep_q     <= 1'b0;
      prev_cur_q  <= '0;
      prev_volt_q <= '0;
    end else if (flush) begin
      run_q   <= '0;
      steep_q <= 1'b0;
    end else if (take) begin
      prev_cur_q  <= cur;
      prev_volt_q <= volt;
      if (over) begin
        if (run_q != {WIN_W{1'b1}}) run_q <= run_q + WIN_W'(1);
        steep_q <= steep_any;
      end else begin
        run_q   <= '0;
        steep_q <= 1'b0;
      end
    end
  end

  AST_RUN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !flush && !(cur > ift)) |=> (run_q == '0)); // R2

  AST_RUN_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !flush) |=> $stable(run_q)); // R2
endmodule

// File: rtl/fs_i2t.sv
// Saturating sum of current squared with a quiet-run clear.
module fs_i2t #(
  parameter int CW    = 12,
  parameter int ACC_W = 32,
  parameter int QW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             take,
  input  logic [CW-1:0]    cur,
  input  logic [CW-1:0]    ilim,
  input  logic [ACC_W-1:0] lim,
  input  logic [QW-1:0]    quiet,
  output logic             hot,
  output logic             over
);
  localparam int SQW = 2 * CW;
  localparam int MW  = (SQW > ACC_W) ? SQW : ACC_W;
  localparam int SW  = MW + 1;

  logic [ACC_W-1:0] acc_q;
  logic [QW-1:0]    qrun_q;
  logic [SQW-1:0]   sq;
  logic [SW-1:0]    sum;
  logic [ACC_W-1:0] sat;
  logic [QW:0]      qrun_inc;

  always_comb begin
    hot      = cur >= ilim;
    sq       = {{CW{1'b0}}, cur} * {{CW{1'b0}}, cur};
    sum      = SW'(acc_q) + SW'(sq);
    sat      = (sum > SW'({ACC_W{1'b1}})) ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
    over     = take && hot && (sat > lim);
    qrun_inc = {1'b0, qrun_q} + (QW+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      qrun_q <= '0;
    end else if (flush) begin
      acc_q  <= '0;
      qrun_q <= '0;
    end else if (take) begin
      if (hot) begin
        acc_q  <= sat;
        qrun_q <= '0;
      end else if (qrun_inc >= {1'b0, quiet}) begin
        acc_q  <= '0;
        qrun_q <= '0;
      end else begin
        qrun_q <= qrun_inc[QW-1:0];
      end
    end
  end

  AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hot && !flush) |=> (acc_q >= $past(acc_q))); // R4

  AST_ACC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !flush) |=> $stable(acc_q)); // R5
endmodule

// File: rtl/fs_trip_supervisor.sv
module fs_trip_supervisor #(
  parameter int CW    = 12,
  parameter int VW    = 12,
  parameter int WIN_W = 8,
  parameter int ACC_W = 32,
  parameter int QW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [CW-1:0]    smp_cur,
  input  logic [VW-1:0]    smp_volt,
  input  logic [CW-1:0]    cfg_ift,
  input  logic [CW-1:0]    cfg_ilim,
  input  logic [WIN_W-1:0] cfg_win,
  input  logic [ACC_W-1:0] cfg_i2t_lim,
  input  logic [QW-1:0]    cfg_quiet,
  input  logic [VW-1:0]    cfg_vdrop,
  input  logic [CW-1:0]    cfg_dirise,
  input  logic             clr,
  output logic             sw_off,
  output logic             fault,
  output logic             limiting,
  output logic [2:0]       evt_code,
  output logic             cfg_bad
);
  import fs_pkg::*;

  logic    fault_q, off_q, lim_q;
  fs_evt_e evt_q;
  logic    take;
  logic    ft_fire, steep_any;
  logic    hot, i2t_over;
  logic    any_trip;
  fs_evt_e evt_next;

  assign smp_ready = rst_n;
  assign take      = smp_valid && smp_ready && !fault_q;

  fs_cfg_check #(.CW(CW)) u_cfg (
    .ift (cfg_ift),
    .ilim(cfg_ilim),
    .bad (cfg_bad)
  );

  fs_window #(.CW(CW), .VW(VW), .WIN_W(WIN_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (clr),
    .take     (take),
    .cur      (smp_cur),
    .volt     (smp_volt),
    .ift      (cfg_ift),
    .win      (cfg_win),
    .vdrop    (cfg_vdrop),
    .dirise   (cfg_dirise),
    .fire     (ft_fire),
    .steep_any(steep_any)
  );

  fs_i2t #(.CW(CW), .ACC_W(ACC_W), .QW(QW)) u_i2t (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(clr),
    .take (take),
    .cur  (smp_cur),
    .ilim (cfg_ilim),
    .lim  (cfg_i2t_lim),
    .quiet(cfg_quiet),
    .hot  (hot),
    .over (i2t_over)
  );

  always_comb begin
    any_trip = take && (cfg_bad || ft_fire || i2t_over);
    if (cfg_bad)      evt_next = EVT_CFG;
    else if (ft_fire) evt_next = steep_any ? EVT_SHORT : EVT_HARD;
    else              evt_next = EVT_LOCKED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      off_q   <= 1'b0;
      lim_q   <= 1'b0;
      evt_q   <= EVT_NONE;
    end else if (clr) begin
      fault_q <= 1'b0;
      off_q   <= 1'b0;
      lim_q   <= 1'b0;
      evt_q   <= EVT_NONE;
    end else if (take) begin
      if (any_trip) begin
        fault_q <= 1'b1;
        off_q   <= 1'b1;
        lim_q   <= 1'b0;
        evt_q   <= evt_next;
      end else begin
        lim_q <= hot;
      end
    end
  end

  assign fault    = fault_q;
  assign sw_off   = off_q;
  assign limiting = lim_q;
  assign evt_code = evt_q;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !clr) |=> (fault && sw_off && $stable(evt_code))); // R8

  AST_CLR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!fault && !sw_off && evt_code == 3'd0)); // R9

  AST_CODE_MATCHES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fault == (evt_code != 3'd0))); // R7

  AST_NO_LIMIT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sw_off |-> !limiting); // R3

  AST_CFG_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cfg_bad && !clr) |=> (fault && evt_code == 3'd4)); // R6
endmodule

// File: tb/fs_trip_supervisor_tb.sv
module fs_trip_supervisor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [11:0] smp_cur = '0;
  logic [11:0] smp_volt = '0;
  logic [11:0] cfg_ift = 12'd1000;
  logic [11:0] cfg_ilim = 12'd700;
  logic [7:0]  cfg_win = 8'd4;
  logic [31:0] cfg_i2t_lim = 32'hFFFF_FFFF;
  logic [7:0]  cfg_quiet = 8'd3;
  logic [11:0] cfg_vdrop = 12'd200;
  logic [11:0] cfg_dirise = 12'd300;
  logic        clr = 1'b0;
  logic        sw_off, fault, limiting, cfg_bad;
  logic [2:0]  evt_code;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fs_trip_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_cur(smp_cur), .smp_volt(smp_volt), .cfg_ift(cfg_ift), .cfg_ilim(cfg_ilim),
    .cfg_win(cfg_win), .cfg_i2t_lim(cfg_i2t_lim), .cfg_quiet(cfg_quiet),
    .cfg_vdrop(cfg_vdrop), .cfg_dirise(cfg_dirise), .clr(clr), .sw_off(sw_off),
    .fault(fault), .limiting(limiting), .evt_code(evt_code), .cfg_bad(cfg_bad)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [11:0] c, input logic [11:0] v);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_cur   = c;
    smp_volt  = v;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "ready", smp_ready, 1);
    chk("R8", "fault at reset", fault, 0);
    chk("R8", "sw_off at reset", sw_off, 0);
    chk("R3", "limiting at reset", limiting, 0);
    chk("R7", "code at reset", evt_code, 0);
    chk("R6", "cfg_bad default", cfg_bad, 0);
  endtask

  task automatic t_spike();
    send(12'd100, 12'd2000);
    for (int i = 0; i < 3; i++) send(12'd1500, 12'd2000);
    send(12'd100, 12'd2000);
    chk("R2", "3-sample spike no trip", fault, 0);
    chk("R3", "limiting low below level", limiting, 0);
  endtask

  task automatic t_hard_gaps();
    send(12'd900, 12'd2000);
    chk("R3", "limiting on plateau", limiting, 1);
    for (int i = 0; i < 3; i++) begin
      send(12'd1100, 12'd2000);
      repeat (5) @(negedge clk);
    end
    chk("R2", "idle cycles do not count", fault, 0);
    send(12'd1100, 12'd2000);
    chk("R2", "trip at window", fault, 1);
    chk("R8", "sw_off with fault", sw_off, 1);
    chk("R7", "hard overcurrent code", evt_code, 3);
    chk("R3", "limiting low when tripped", limiting, 0);
    pulse_clr();
    chk("R9", "clr drops fault", fault, 0);
    chk("R9", "clr drops sw_off", sw_off, 0);
    chk("R9", "clr zeroes code", evt_code, 0);
  endtask

  task automatic t_short();
    send(12'd100, 12'd2000);
    send(12'd1500, 12'd1500);
    send(12'd1500, 12'd1500);
    send(12'd1500, 12'd1500);
    chk("R2", "one short of window", fault, 0);
    send(12'd1500, 12'd1500);
    chk("R7", "cable short code", evt_code, 1);
    send(12'd100, 12'd2000);
    send(12'd800, 12'd2000);
    chk("R8", "tripped sample ignored code", evt_code, 1);
    chk("R8", "tripped sample ignored limiting", limiting, 0);
    pulse_clr();
  endtask

  task automatic t_i2t();
    cfg_i2t_lim = 32'd1920000;
    for (int i = 0; i < 3; i++) send(12'd800, 12'd2000);
    chk("R4", "budget reached not exceeded", fault, 0);
    chk("R3", "limiting during plateau", limiting, 1);
    send(12'd800, 12'd2000);
    chk("R4", "budget exceeded trips", fault, 1);
    chk("R7", "locked rotor code", evt_code, 2);
    pulse_clr();
  endtask

  task automatic t_quiet();
    for (int i = 0; i < 3; i++) send(12'd800, 12'd2000);
    for (int i = 0; i < 3; i++) send(12'd500, 12'd2000);
    for (int i = 0; i < 3; i++) send(12'd800, 12'd2000);
    chk("R5", "full quiet run clears total", fault, 0);
    send(12'd800, 12'd2000);
    chk("R5", "trip after refill", evt_code, 2);
    pulse_clr();
    for (int i = 0; i < 3; i++) send(12'd800, 12'd2000);
    for (int i = 0; i < 2; i++) send(12'd500, 12'd2000);
    send(12'd800, 12'd2000);
    chk("R5", "short quiet run keeps total", evt_code, 2);
    pulse_clr();
  endtask

  task automatic t_sat();
    cfg_i2t_lim = 32'hFFFF_FFFE;
    for (int i = 0; i < 4303; i++) send(12'd999, 12'd2000);
    chk("R4", "below full scale", fault, 0);
    send(12'd999, 12'd2000);
    chk("R4", "saturated total trips", fault, 1);
    chk("R4", "saturated code", evt_code, 2);
    pulse_clr();
  endtask

  task automatic t_priority();
    cfg_i2t_lim = 32'd1;
    cfg_win = 8'd1;
    send(12'd100, 12'd2000);
    send(12'd1500, 12'd1500);
    chk("R10", "fast short beats energy", evt_code, 1);
    pulse_clr();
    cfg_win = 8'd0;
    send(12'd1100, 12'd1500);
    chk("R10", "window 0 as 1, hard beats energy", evt_code, 3);
    pulse_clr();
    cfg_win = 8'd4;
    cfg_i2t_lim = 32'hFFFF_FFFF;
  endtask

  task automatic t_cfg();
    cfg_ilim = 12'd800;
    #1;
    chk("R6", "exactly 0.8 accepted", cfg_bad, 0);
    cfg_ilim = 12'd801;
    #1;
    chk("R6", "above 0.8 rejected", cfg_bad, 1);
    send(12'd1500, 12'd2000);
    chk("R10", "config reject wins", evt_code, 4);
    pulse_clr();
    cfg_ilim = 12'd700;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_spike();
    t_hard_gaps();
    t_short();
    t_i2t();
    t_quiet();
    t_sat();
    t_priority();
    t_cfg();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule